// File: doc/BRIEF.md
# Data Pointer Address Generator

This unit produces the memory address for register-indirect data accesses in a signal-processing core. It also moves its pointer to the next address, so the datapath spends no cycles on address arithmetic. Software loads a small register set through a write port: the pointer, a signed step, a lower and an upper bound, a block length, an addressing mode and the log2 of an FFT size. Each access then uses that configuration.

On an access, the caller chooses the order of the update. With post-update, the address presented is the current pointer and the pointer advances afterwards. With pre-update, the advanced value is presented and also kept as the new pointer. Four addressing modes are available. Linear mode steps forward or backward by any amount. Bounded circular mode wraps between an inclusive lower and upper address. Aligned circular mode works within a power-of-two-aligned block and uses only a length. Bit-reversed mode walks the index field in radix-2 FFT order.

The next-address logic is purely combinational. The presented address is valid in the same cycle as the access request, and the pointer register updates on the following clock edge.

Top module: `agu_top`

## Requirements
- R1: After reset, every register reads as zero except the FFT size log2, which is 1, and the mode is linear (code 0). Write select codes: 0 pointer, 1 step, 2 lower bound, 3 upper bound, 4 length, 5 mode (low two bits), 6 FFT log2. Code 7 changes nothing.
- R2: Post-update access: `ea` equals the current pointer, and on the next edge the pointer takes the advanced value.
- R3: Pre-update access: `ea` equals the advanced value, and the pointer holds that same value after the edge.
- R4: Linear mode (code 0) advances by adding the signed step modulo 2^AW.
- R5: Bounded circular mode (code 1) uses the inclusive range lower..upper, with span S = upper - lower + 1. A sum above upper is reduced by S, and a sum below lower is raised by S. For |step| <= S, an in-range pointer stays in range.
- R6: Aligned circular mode (code 2) splits the pointer into a fixed base and an offset. The offset is the pointer's low b bits, where b is the bit count of length-1; the base is the remaining upper bits. The offset advances modulo length, for length >= 1.
- R7: Bit-reversed mode (code 3) uses an index field of K low bits, where K is the FFT log2. The field advances by adding the step to its bit-reversed value, wrapping modulo 2^K, and reversing back. Bits at and above K never change. With K=3 and step +1 from index 0, the order is 0,4,2,6,1,5,3,7.
- R8: A written FFT log2 of 0 is stored as 1. Values above MAXLOG are stored as MAXLOG.
- R9: With no access and no pointer write, the pointer holds. A write to any other register leaves it unchanged. With `acc_pre` low, `ea` shows the pointer.
- R10: If a pointer write and an access fall in the same cycle, the written value is stored and the update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | AW | Register write data |
| acc_en | input | 1 | Access request this cycle |
| acc_pre | input | 1 | 1 = pre-update, 0 = post-update |
| ea | output | AW | Effective address of the access |
| ptr_out | output | AW | Current pointer |

## Verification
The bench keeps the default widths: a 16-bit address and a largest FFT size of 1024 points. With these settings it can walk the full 1024-entry bit-reversed sequence, and it can wrap the linear pointer across the top of the 16-bit space. It sweeps every mode for both update orders and both step signs. The cases include a step equal to the circular span, aligned lengths that are and are not powers of two, and an index field with nonzero bits above K. The clamp limits of the FFT size register are also checked.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AM_LINEAR = 2'd0,
    AM_BOUNDS = 2'd1,
    AM_BLOCK  = 2'd2,
    AM_BITREV = 2'd3
  } agu_mode_e;

  typedef enum logic [2:0] {
    RS_PTR  = 3'd0,
    RS_STEP = 3'd1,
    RS_LO   = 3'd2,
    RS_HI   = 3'd3,
    RS_LEN  = 3'd4,
    RS_MODE = 3'd5,
    RS_FFT  = 3'd6
  } agu_sel_e;
endpackage

// File: rtl/agu_regs.sv
module agu_regs #(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  localparam int LW    = $clog2(MAXLOG + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [2:0]          cfg_sel,
  input  logic [AW-1:0]       cfg_wdata,
  input  logic                upd_en,
  input  logic [AW-1:0]       upd_addr,
  output logic [AW-1:0]       ptr_q,
  output logic [AW-1:0]       step_q,
  output logic [AW-1:0]       lo_q,
  output logic [AW-1:0]       hi_q,
  output logic [AW-1:0]       len_q,
  output agu_pkg::agu_mode_e  mode_q,
  output logic [LW-1:0]       fft_q
);
  import agu_pkg::*;

  function automatic logic [LW-1:0] clamp_log(input logic [AW-1:0] v);
    if (v == '0)               return LW'(1);
    else if (v > AW'(MAXLOG))  return LW'(MAXLOG);
    else                       return v[LW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      step_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      len_q  <= '0;
      mode_q <= AM_LINEAR;
      fft_q  <= LW'(1);
    end else begin
      if (upd_en) ptr_q <= upd_addr;
      if (cfg_we) begin
        case (cfg_sel)
          RS_PTR:  ptr_q  <= cfg_wdata;
          RS_STEP: step_q <= cfg_wdata;
          RS_LO:   lo_q   <= cfg_wdata;
          RS_HI:   hi_q   <= cfg_wdata;
          RS_LEN:  len_q  <= cfg_wdata;
          RS_MODE: mode_q <= agu_mode_e'(cfg_wdata[1:0]);
          RS_FFT:  fft_q  <= clamp_log(cfg_wdata);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/agu_next.sv
module agu_next #(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  localparam int LW    = $clog2(MAXLOG + 1),
  localparam int SW    = AW + 2
) (
  input  logic [AW-1:0]       ptr,
  input  logic [AW-1:0]       step,
  input  logic [AW-1:0]       lo,
  input  logic [AW-1:0]       hi,
  input  logic [AW-1:0]       len,
  input  agu_pkg::agu_mode_e  mode,
  input  logic [LW-1:0]       fft_log,
  output logic [AW-1:0]       nxt,
  output logic                wrap
);
  import agu_pkg::*;

  localparam logic signed [SW-1:0] ONE = SW'(1);

  function automatic logic signed [SW-1:0] sx(input logic [AW-1:0] v);
    return $signed({{2{v[AW-1]}}, v});
  endfunction

  function automatic logic signed [SW-1:0] zx(input logic [AW-1:0] v);
    return $signed({2'b00, v});
  endfunction

  // returns {wrapped, address}
  function automatic logic [AW:0] step_bounds(input logic [AW-1:0] p, m, l, h);
    logic signed [SW-1:0] s, span;
    s    = zx(p) + sx(m);
    span = zx(h) - zx(l) + ONE;
    if (s > zx(h))      return {1'b1, AW'(s - span)};
    else if (s < zx(l)) return {1'b1, AW'(s + span)};
    else                return {1'b0, AW'(s)};
  endfunction

  function automatic logic [AW-1:0] fill_low(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = v;
    for (int sh = 1; sh < AW; sh = sh * 2) r = r | (r >> sh);
    return r;
  endfunction

  function automatic logic [AW:0] step_block(input logic [AW-1:0] p, m, n);
    logic [AW-1:0]        mask;
    logic signed [SW-1:0] off;
    logic                 w;
    mask = fill_low(n - AW'(1));
    off  = zx(p & mask) + sx(m);
    w    = 1'b0;
    if (off >= zx(n)) begin
      off = off - zx(n);
      w   = 1'b1;
    end else if (off[SW-1]) begin
      off = off + zx(n);
      w   = 1'b1;
    end
    return {w, (p & ~mask) | (AW'(off) & mask)};
  endfunction

  function automatic logic [MAXLOG-1:0] rev_low(input logic [MAXLOG-1:0] x,
                                                input logic [LW-1:0] k);
    logic [MAXLOG-1:0] f;
    for (int i = 0; i < MAXLOG; i++) f[i] = x[MAXLOG-1-i];
    return f >> (LW'(MAXLOG) - k);
  endfunction

  function automatic logic [AW-1:0] step_rev(input logic [AW-1:0] p, m,
                                             input logic [LW-1:0] k);
    logic [MAXLOG-1:0] fmask, idx, c;
    fmask = MAXLOG'((1 << k) - 1);
    idx   = p[MAXLOG-1:0] & fmask;
    c     = (rev_low(idx, k) + m[MAXLOG-1:0]) & fmask;
    return {p[AW-1:MAXLOG], (p[MAXLOG-1:0] & ~fmask) | rev_low(c, k)};
  endfunction

  always_comb begin
    wrap = 1'b0;
    case (mode)
      AM_BOUNDS: {wrap, nxt} = step_bounds(ptr, step, lo, hi);
      AM_BLOCK:  {wrap, nxt} = step_block(ptr, step, len);
      AM_BITREV: nxt = step_rev(ptr, step, fft_log);
      default:   nxt = ptr + step;
    endcase
  end
endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int AW     = 16,
  parameter int MAXLOG = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          acc_en,
  input  logic          acc_pre,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] ptr_out
);
  import agu_pkg::*;
  localparam int LW = $clog2(MAXLOG + 1);

  logic [AW-1:0] ptr_q, step_q, lo_q, hi_q, len_q, nxt_addr;
  agu_mode_e     mode_q;
  logic [LW-1:0] fft_q;
  logic          wrap_evt;
  logic          ptr_wr_evt;
  logic          upd_evt;

  assign ptr_wr_evt = cfg_we && (cfg_sel == RS_PTR);
  assign upd_evt    = acc_en && !ptr_wr_evt;

  agu_regs #(.AW(AW), .MAXLOG(MAXLOG)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .upd_en(upd_evt), .upd_addr(nxt_addr),
    .ptr_q(ptr_q), .step_q(step_q), .lo_q(lo_q), .hi_q(hi_q),
    .len_q(len_q), .mode_q(mode_q), .fft_q(fft_q)
  );

  agu_next #(.AW(AW), .MAXLOG(MAXLOG)) next_i (
    .ptr(ptr_q), .step(step_q), .lo(lo_q), .hi(hi_q), .len(len_q),
    .mode(mode_q), .fft_log(fft_q), .nxt(nxt_addr), .wrap(wrap_evt)
  );

  assign ea      = acc_pre ? nxt_addr : ptr_q;
  assign ptr_out = ptr_q;
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW     = 16,
  parameter int MAXLOG = 10,
  localparam int LW    = $clog2(MAXLOG + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_en,
  input logic          acc_pre,
  input logic          cfg_we,
  input logic [AW-1:0] cfg_wdata,
  input logic          ptr_wr_evt,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] ptr,
  input logic [AW-1:0] nxt,
  input logic [AW-1:0] step,
  input logic [AW-1:0] lo,
  input logic [AW-1:0] hi,
  input logic [1:0]    mode,
  input logic [LW-1:0] fft_log
);
  logic [AW:0] span_w, mag_w;
  logic        in_rng;
  assign span_w = {1'b0, hi} - {1'b0, lo} + (AW+1)'(1);
  assign mag_w  = {1'b0, step[AW-1] ? (~step + AW'(1)) : step};
  assign in_rng = (ptr >= lo) && (ptr <= hi);

  p_post_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && !acc_pre && !ptr_wr_evt |=> ptr == $past(nxt));

  p_pre_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en && acc_pre && !ptr_wr_evt |=> ptr == $past(ea));

  p_stay_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) && acc_en && !cfg_we && (lo <= hi) && in_rng
      && (mag_w <= span_w) |=> (ptr >= lo) && (ptr <= hi));

  p_rev_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) && acc_en && !cfg_we
      |=> (ptr >> fft_log) == ($past(ptr) >> fft_log));

  p_fft_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fft_log >= LW'(1)) && (fft_log <= LW'(MAXLOG)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en && !ptr_wr_evt |=> $stable(ptr));

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr_evt |=> ptr == $past(cfg_wdata));
endmodule

bind agu_top agu_chk #(.AW(AW), .MAXLOG(MAXLOG)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_pre(acc_pre),
  .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ptr_wr_evt(ptr_wr_evt),
  .ea(ea), .ptr(ptr_q), .nxt(nxt_addr), .step(step_q), .lo(lo_q),
  .hi(hi_q), .mode(mode_q), .fft_log(fft_q)
);

// File: tb/agu_top_tb_top.sv
module agu_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        acc_en = 1'b0;
  logic        acc_pre = 1'b0;
  logic [15:0] ea, ptr_out;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  agu_top #(.AW(16), .MAXLOG(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_en(acc_en), .acc_pre(acc_pre),
    .ea(ea), .ptr_out(ptr_out)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int sel, input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel[2:0]; cfg_wdata = v[15:0];
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic access(input bit pre, output int got);
    @(negedge clk);
    acc_en = 1'b1; acc_pre = pre;
    #1 got = int'(ea);
    @(posedge clk); #1;
    acc_en = 1'b0; acc_pre = 1'b0;
  endtask

  function automatic int brev(input int x, input int k);
    int r = 0;
    for (int i = 0; i < k; i++) if (((x >> i) & 1) != 0) r |= 1 << (k - 1 - i);
    return r;
  endfunction

  function automatic int wrapmod(input int v, input int n);
    return ((v % n) + n) % n;
  endfunction

  function automatic int adv(input int md, input int p, input int m, input int lo,
                             input int hi, input int ln, input int k);
    int n, base, blk;
    case (md)
      1: begin
        n = hi - lo + 1;
        return lo + wrapmod(p - lo + m, n);
      end
      2: begin
        blk = 1;
        while (blk < ln) blk = blk * 2;
        base = p - (p % blk);
        return base + wrapmod((p % blk) + m, ln);
      end
      3: begin
        n = 1 << k;
        base = p - (p % n);
        return base + brev(wrapmod(brev(p % n, k) + m, n), k);
      end
      default: return wrapmod(p + m, 65536);
    endcase
  endfunction

  task automatic run(input int md, input int p0, input int m, input int lo, input int hi,
                     input int ln, input int kwr, input int keff, input bit pre,
                     input int steps, input string tag);
    int p, exp, got;
    wr(0, p0); wr(1, m); wr(2, lo); wr(3, hi); wr(4, ln); wr(5, md); wr(6, kwr);
    p = p0;
    for (int i = 0; i < steps; i++) begin
      if (pre) begin
        p = adv(md, p, m, lo, hi, ln, keff);
        exp = p;
      end else begin
        exp = p;
        p = adv(md, p, m, lo, hi, ln, keff);
      end
      access(pre, got);
      check($sformatf("%s step %0d", tag, i), got, exp);
    end
    #1 check({tag, " final ptr"}, int'(ptr_out), p);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int got;
    int exp8[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset ptr", int'(ptr_out), 0);
    check("R1 reset ea", int'(ea), 0);
    wr(1, 1);
    access(1'b0, got);
    check("R1 R2 default linear post ea", got, 0);
    check("R1 default linear ptr", int'(ptr_out), 1);
    // R1 select code 7 is ignored
    wr(7, 16'h5555);
    #1 check("R1 select 7 ptr", int'(ptr_out), 1);

    // R4 linear, both orders and signs (R2, R3)
    run(0, 16'hFFF0, 3, 0, 0, 0, 1, 1, 1'b0, 20, "R4 R2 linear +3 post");
    run(0, 16'h0008, -5, 0, 0, 0, 1, 1, 1'b1, 20, "R4 R3 linear -5 pre");

    // R5 bounded circular
    run(1, 100, 3, 100, 109, 0, 1, 1, 1'b0, 30, "R5 bounds +3 post");
    run(1, 105, -4, 100, 109, 0, 1, 1, 1'b1, 30, "R5 bounds -4 pre");
    run(1, 107, 10, 100, 109, 0, 1, 1, 1'b0, 5, "R5 bounds step=span");
    run(1, 16'hFFFC, 2, 16'hFFF8, 16'hFFFF, 0, 1, 1, 1'b1, 12, "R5 bounds top of space");

    // R6 aligned circular
    run(2, 16'h2345, 5, 0, 0, 12, 1, 1, 1'b0, 30, "R6 block len12 +5 post");
    run(2, 16'h2345, -7, 0, 0, 12, 1, 1, 1'b1, 30, "R6 block len12 -7 pre");
    run(2, 16'h0713, 3, 0, 0, 16, 1, 1, 1'b0, 20, "R6 block len16 +3 post");
    run(2, 16'h0103, -1, 0, 0, 5, 1, 1, 1'b1, 12, "R6 block len5 -1 pre");

    // R7 bit-reversed: explicit 8-point order
    wr(0, 16'h0400); wr(1, 1); wr(5, 3); wr(6, 3);
    for (int i = 0; i < 8; i++) begin
      access(1'b0, got);
      check($sformatf("R7 8-point order %0d", i), got, 16'h0400 + exp8[i]);
    end
    run(3, 16'hA000, 1, 0, 0, 0, 10, 10, 1'b1, 1024, "R7 bitrev 1024 pre");
    run(3, 16'h1230, -1, 0, 0, 0, 4, 4, 1'b0, 20, "R7 bitrev k4 -1 post");
    run(3, 16'hFFE0, 3, 0, 0, 0, 5, 5, 1'b1, 40, "R7 bitrev k5 +3 pre");

    // R8 clamp of FFT size
    run(3, 16'h0F00, 1, 0, 0, 0, 0, 1, 1'b0, 6, "R8 fft write 0 clamps to 1");
    run(3, 16'h3C00, 1, 0, 0, 0, 15, 10, 1'b0, 8, "R8 fft write 15 clamps to 10");

    // R9 idle hold and unrelated writes
    wr(0, 16'h4321); wr(5, 0); wr(1, 7);
    repeat (3) @(negedge clk);
    #1 check("R9 idle ptr", int'(ptr_out), 16'h4321);
    check("R9 ea shows ptr", int'(ea), 16'h4321);
    wr(2, 16'h1111); wr(4, 9);
    #1 check("R9 other writes ptr", int'(ptr_out), 16'h4321);

    // R10 pointer write beats access update
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'h1234;
    acc_en = 1'b1; acc_pre = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0; acc_en = 1'b0; acc_pre = 1'b0;
    check("R10 write wins", int'(ptr_out), 16'h1234);
    access(1'b0, got);
    check("R10 next access ea", got, 16'h1234);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule